// File: doc/BRIEF.md
# Learning Address Filter With Aging

This block is the forwarding decision stage of a two-segment bridge. It holds a small table of station addresses heard as senders on the local segment. For every packet it is given the sender and target addresses. It learns or refreshes the sender in the table, and it tells the bridge whether to pass the packet to the other segment or drop it. A packet is dropped when its target is a unicast station already known to live on the local segment. Every other packet is passed on.

Each table slot has a valid flag and an age count. A periodic tick advances the age of every occupied slot. A slot whose address has been silent for longer than a programmable limit is freed, so stations that left the segment are forgotten. When every slot is occupied and a new sender shows up, the stalest slot is overwritten.

Requests use a simple handshake. The filter accepts a request in the cycle it is raised, and gives a registered verdict in the following cycle. Parsing addresses out of frames and storing packets are left to neighbouring logic.

Top module: `addr_learn_filter`

## Requirements
- R1: While reset is applied and after it is released, no slot is occupied, and `rsp_valid_o` and `rsp_fwd_o` are both 0 until a request is accepted.
- R2: `ack_o` equals `req_i` in the same cycle, so every request is accepted at once. `rsp_valid_o` is 1 in exactly the cycles that follow an accepted request. `rsp_fwd_o` is 0 whenever `rsp_valid_o` is 0.
- R3: A target whose group bit is set is always forwarded (`rsp_fwd_o`=1), even if that address sits in the table. The group bit is bit 40 of the 48-bit address, which is the least significant bit of its most significant byte.
- R4: A unicast target equal to the address of an occupied slot gives `rsp_fwd_o`=0 (discard). A unicast target that matches no occupied slot gives `rsp_fwd_o`=1.
- R5: The target verdict uses the table as it stood before this same request learned its sender. A packet whose sender and target are the same new address is forwarded, and a repeat of it is discarded.
- R6: After an accepted request, the sender address occupies exactly one slot. An unknown sender gets a new slot, and a known sender is never duplicated.
- R7: An accepted request sets its sender's age to 0. Each tick adds 1 to the age of every occupied slot.
- R8: On a tick, an occupied slot whose age is already greater than or equal to `age_limit_i` is freed. An address that has not been sent from for `age_limit_i`+1 ticks therefore stops being discarded as a target.
- R9: A new sender takes the lowest-numbered free slot. If no slot is free, it takes the slot with the greatest age, and among equal ages the lowest-numbered one.
- R10: When a tick and a request fall in the same cycle, the request's sender ends up occupied with age 0, even if the tick would have freed it. Its target verdict still sees the table as it stood before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Packet lookup request |
| req_src_i | input | 48 | Sender address of the packet |
| req_dst_i | input | 48 | Target address of the packet |
| ack_o | output | 1 | Request accepted this cycle |
| age_tick_i | input | 1 | One-cycle aging pulse |
| age_limit_i | input | 8 | Largest age an entry may keep across a tick |
| rsp_valid_o | output | 1 | Verdict valid, one cycle after acceptance |
| rsp_fwd_o | output | 1 | 1 = forward the packet, 0 = discard it |

## Verification
Some properties are checked on every cycle. These are the handshake timing, the forced forwarding of group targets, and that a just-served sender sits in exactly one slot with age zero. Other behaviours only show up across a sequence of requests and ticks. These are expiry after the limit, which slot a full table gives up under age ties, the verdict being taken before the packet's own learning, and a refresh beating expiry in a shared cycle. The bench exposes them by later probing the table with target lookups against a reference model.

// File: rtl/alf_pkg.sv
package alf_pkg;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = MAC_W - 8;

    typedef logic [MAC_W-1:0] mac_t;

    // group (broadcast/multicast) flag sits in the LSB of the top byte
    function automatic logic is_group(input mac_t a);
        return a[GROUP_BIT];
    endfunction
endpackage

// File: rtl/alf_match.sv
module alf_match
    import alf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][MAC_W-1:0] tab_i,
    input  mac_t                          key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_i[g] && (tab_i[g] == key_i);
    end

    always_comb begin
        hit_o = |hit_vec;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/alf_victim.sv
module alf_victim #(
    parameter int ENTRIES = 16,
    parameter int AGE_W   = 8,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][AGE_W-1:0] age_i,
    output logic [IDX_W-1:0]              idx_o
);
    logic              have_free;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  old_idx;
    logic [AGE_W-1:0]  old_age;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_i[i] && !have_free) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        // strict compare keeps the lowest index on equal ages
        old_idx = '0;
        old_age = age_i[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (age_i[i] > old_age) begin
                old_age = age_i[i];
                old_idx = IDX_W'(i);
            end
        end
        idx_o = have_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/addr_learn_filter.sv
module addr_learn_filter
    import alf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AGE_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [47:0]      req_src_i,
    input  logic [47:0]      req_dst_i,
    output logic             ack_o,
    input  logic             age_tick_i,
    input  logic [AGE_W-1:0] age_limit_i,
    output logic             rsp_valid_o,
    output logic             rsp_fwd_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][MAC_W-1:0] addr;
        logic [ENTRIES-1:0][AGE_W-1:0] age;
        logic                          rsp_valid;
        logic                          rsp_fwd;
    } state_t;

    state_t st_q, st_d;

    logic             src_hit;
    logic [IDX_W-1:0] src_idx;
    logic             dst_hit;
    logic [IDX_W-1:0] unused_dst_idx;
    logic [IDX_W-1:0] vic_idx;

    alf_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_src_match (
        .valid_i (st_q.valid),
        .tab_i   (st_q.addr),
        .key_i   (req_src_i),
        .hit_o   (src_hit),
        .idx_o   (src_idx)
    );

    alf_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dst_match (
        .valid_i (st_q.valid),
        .tab_i   (st_q.addr),
        .key_i   (req_dst_i),
        .hit_o   (dst_hit),
        .idx_o   (unused_dst_idx)
    );

    alf_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .valid_i (st_q.valid),
        .age_i   (st_q.age),
        .idx_o   (vic_idx)
    );

    assign ack_o = req_i;

    always_comb begin
        st_d = st_q;

        // verdict is taken from the table before this cycle's updates
        st_d.rsp_valid = req_i;
        st_d.rsp_fwd   = req_i && (is_group(req_dst_i) || !dst_hit);

        // aging: free entries already at the limit, advance the others
        if (age_tick_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.valid[i]) begin
                    if (st_q.age[i] >= age_limit_i) begin
                        st_d.valid[i] = 1'b0;
                    end else begin
                        st_d.age[i] = st_q.age[i] + 1'b1;
                    end
                end
            end
        end

        // learning wins over aging for the sender slot
        if (req_i) begin
            if (src_hit) begin
                st_d.valid[src_idx] = 1'b1;
                st_d.age[src_idx]   = '0;
            end else begin
                st_d.valid[vic_idx] = 1'b1;
                st_d.addr[vic_idx]  = req_src_i;
                st_d.age[vic_idx]   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_fwd_o   = st_q.rsp_fwd;
endmodule

// File: rtl/alf_checker.sv
module alf_checker
    import alf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AGE_W   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_i,
    input logic [47:0]                   req_src_i,
    input logic [47:0]                   req_dst_i,
    input logic                          ack_o,
    input logic                          rsp_valid_o,
    input logic                          rsp_fwd_o,
    input logic [ENTRIES-1:0]            tab_valid,
    input logic [ENTRIES-1:0][MAC_W-1:0] tab_addr,
    input logic [ENTRIES-1:0][AGE_W-1:0] tab_age
);
    logic               acc_q;
    mac_t               src_q;
    logic [ENTRIES-1:0] src_seen;
    logic               src_stale;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            src_q <= '0;
        end else begin
            acc_q <= ack_o;
            src_q <= req_src_i;
        end
    end

    always_comb begin
        src_stale = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            src_seen[i] = tab_valid[i] && (tab_addr[i] == src_q);
            if (src_seen[i] && (tab_age[i] != '0)) src_stale = 1'b1;
        end
    end

    // R2
    ack_tracks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o == req_i);

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> rsp_valid_o);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |=> !rsp_valid_o);

    // R1
    fwd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> !rsp_fwd_o);

    // R3
    group_dst_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && is_group(req_dst_i)) |=> rsp_fwd_o);

    // R6
    src_single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> ($countones(src_seen) == 1));

    // R7
    src_age_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> !src_stale);
endmodule

bind addr_learn_filter alf_checker #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_alf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .req_src_i   (req_src_i),
    .req_dst_i   (req_dst_i),
    .ack_o       (ack_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fwd_o   (rsp_fwd_o),
    .tab_valid   (st_q.valid),
    .tab_addr    (st_q.addr),
    .tab_age     (st_q.age)
);

// File: tb/addr_learn_filter_bench.sv
module addr_learn_filter_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [47:0] src = '0;
    logic [47:0] dst = '0;
    logic        tick = 1'b0;
    logic [7:0]  limit = 8'd255;
    logic        ack, rsp_valid, rsp_fwd;

    int vecs = 0;
    int bad  = 0;

    bit          mv[N];
    logic [47:0] ma[N];
    int          mg[N];

    always #4 clk = ~clk;

    addr_learn_filter u_addr_learn_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .req_src_i   (src),
        .req_dst_i   (dst),
        .ack_o       (ack),
        .age_tick_i  (tick),
        .age_limit_i (limit),
        .rsp_valid_o (rsp_valid),
        .rsp_fwd_o   (rsp_fwd)
    );

    function automatic logic [47:0] uni(input int k);
        return 48'h0200_0000_0000 | 48'(k);
    endfunction

    function automatic logic [47:0] grp(input int k);
        return 48'h0100_0000_0000 | 48'(k);
    endfunction

    // R3 R4: expected verdict from the model before any update
    function automatic bit exp_fwd(input logic [47:0] d);
        if (d[40]) return 1'b1;
        for (int i = 0; i < N; i++) if (mv[i] && ma[i] == d) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            mv[i] = 1'b0; ma[i] = '0; mg[i] = 0;
        end
    endtask

    // R6 R7 R8 R9 R10: reference table update
    task automatic model_step(input bit r, input logic [47:0] s, input bit t, input int lim);
        int  hit_i;
        int  vic;
        int  best;
        hit_i = -1;
        for (int i = N - 1; i >= 0; i--) if (mv[i] && ma[i] == s) hit_i = i;
        vic = -1;
        for (int i = 0; i < N; i++) if (!mv[i] && vic < 0) vic = i;
        if (vic < 0) begin
            vic = 0; best = mg[0];
            for (int i = 1; i < N; i++) if (mg[i] > best) begin best = mg[i]; vic = i; end
        end
        if (t) begin
            for (int i = 0; i < N; i++) if (mv[i]) begin
                if (mg[i] >= lim) mv[i] = 1'b0;
                else mg[i] = mg[i] + 1;
            end
        end
        if (r) begin
            if (hit_i >= 0) begin
                mv[hit_i] = 1'b1; mg[hit_i] = 0;
            end else begin
                mv[vic] = 1'b1; ma[vic] = s; mg[vic] = 0;
            end
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: inputs set after a falling edge, verdict read at the next one
    task automatic drive(input bit r, input logic [47:0] s, input logic [47:0] d,
                         input bit t, input string tag);
        bit e;
        req = r; src = s; dst = d; tick = t;
        #1;
        check("R2", "ack", int'(ack), int'(r));
        e = r ? exp_fwd(d) : 1'b0;
        model_step(r, s, t, int'(limit));
        @(negedge clk);
        check("R2", "rsp_valid", int'(rsp_valid), int'(r));
        check(tag, "rsp_fwd", int'(rsp_fwd), int'(e));
        req = 1'b0; tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 1'b0; tick = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        check("R1", "rsp_fwd in reset", int'(rsp_fwd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        do_reset();

        // R1: empty table forwards a unicast target
        drive(1, uni(50), uni(77), 0, "R1");
        // R5: same new address as sender and target, then a repeat
        drive(1, uni(1), uni(1), 0, "R5");
        drive(1, uni(1), uni(1), 0, "R5");
        // R4: known and unknown unicast targets
        drive(1, uni(2), uni(1), 0, "R4");
        drive(1, uni(3), uni(9), 0, "R4");
        // R3: a group address learned as sender is still forwarded as target
        drive(1, grp(5), uni(2), 0, "R4");
        drive(1, uni(2), grp(5), 0, "R3");

        // R8: expiry with limit 2
        do_reset();
        limit = 8'd2;
        drive(1, uni(10), uni(60), 0, "R8");
        drive(0, '0, '0, 1, "R8");
        drive(0, '0, '0, 1, "R8");
        drive(1, uni(11), uni(10), 0, "R8");
        drive(0, '0, '0, 1, "R8");
        drive(1, uni(12), uni(10), 0, "R8");

        // R7 R10: refresh in a tick cycle beats expiry
        do_reset();
        limit = 8'd2;
        drive(1, uni(20), uni(61), 0, "R7");
        drive(0, '0, '0, 1, "R7");
        drive(0, '0, '0, 1, "R7");
        drive(1, uni(20), uni(20), 1, "R10");
        drive(0, '0, '0, 1, "R7");
        drive(0, '0, '0, 1, "R7");
        drive(1, uni(21), uni(20), 0, "R7");
        drive(0, '0, '0, 1, "R8");
        drive(1, uni(22), uni(20), 0, "R8");

        // R9: full table eviction by age, then by lowest index on a tie
        do_reset();
        limit = 8'd255;
        for (int k = 0; k < N; k++) drive(1, uni(100 + k), uni(99), 0, "R9");
        drive(0, '0, '0, 1, "R9");
        for (int k = 0; k < N; k++) if (k != 3) drive(1, uni(100 + k), uni(99), 0, "R9");
        drive(1, uni(200), uni(103), 0, "R9");
        drive(1, uni(201), uni(103), 0, "R9");
        drive(1, uni(202), uni(100), 0, "R9");
        drive(1, uni(203), uni(101), 0, "R9");

        // random traffic over a small address pool
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [47:0] s;
            logic [47:0] d;
            bit r;
            bit t;
            if (n % 500 == 0) limit = 8'($urandom_range(0, 7));
            r = ($urandom_range(0, 9) != 0);
            t = ($urandom_range(0, 3) == 0);
            s = uni($urandom_range(0, 23));
            if ($urandom_range(0, 9) == 0) d = grp($urandom_range(0, 3));
            else d = uni($urandom_range(0, 23));
            drive(r, s, d, t, d[40] ? "R3" : "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule